// File: doc/BRIEF.md
# SMBus Byte-Addressed Memory Target

This block is a bus target on a two-wire open-drain serial bus. Behind one 7-bit bus address it holds a 256-byte memory. The bus clock and data lines come in as raw samples. The block pulls the data line low through a single output-enable pin and never drives the clock line. Both inputs pass through two-flop synchronizers. START and STOP are recognised as data-line edges that occur while the clock line is high.

Two transfers are served. In a write transfer, the first data byte after the address becomes the new internal pointer. Each later byte is stored at the pointer, and the pointer then steps forward by one. In a read transfer, the target returns the byte at the pointer and steps the pointer forward. It keeps sending bytes for as long as the controller acknowledges them.

The pointer is 8 bits wide and wraps from 255 to 0, so the whole array behaves as one circular page. Reset reloads a computed preset image into the array, clears the pointer, and clears a sticky flag that records whether any data byte has been moved.

Top module: `smbus_mem_target`

## Requirements
- R1: The target answers only bus address 0x50 + INST_IDX (INST_IDX 0..7, default 3, giving 0x53). It pulls SDA low during the ninth clock of its own address byte. For any other address it leaves SDA released for the whole transfer, and neither the memory, the pointer nor the flag changes.
- R2: In a write transfer, the first byte after the address is loaded into the pointer and is not stored in the memory. Every byte of a write transfer is acknowledged by SDA low in its ninth clock.
- R3: Each byte after the first in a write transfer is stored at the pointer, and the pointer then advances by one, wrapping from 0xFF to 0x00.
- R4: A read transfer returns the byte at the pointer, most significant bit first, and the pointer then advances by one modulo 256. If the controller acknowledges, the next byte follows. If it does not acknowledge, the target releases SDA and leaves the transfer.
- R5: Reset loads memory byte i with (37*i + 0x5B) mod 256, sets the pointer to 0, releases SDA and clears touched_o.
- R6: touched_o goes high when the first data byte is written or read after reset, and stays high until the next reset.
- R7: A repeated START restarts address decoding and keeps the pointer, so a write of only a pointer byte followed by a repeated START and a read returns the byte at that pointer.
- R8: A STOP (SDA rising while SCL is high) releases SDA and returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low reset; reloads the preset image |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_oe_o | output | 1 | High pulls the data line low |
| touched_o | output | 1 | Sticky flag: a data byte has been moved since reset |

## Verification
The bench sends a write of FE, A1, A2, A3 so that the data crosses the top of the array. A design that does not wrap the pointer would lose the third byte or put it at the wrong location. A read-back of a pointer-only write checks that the pointer byte never lands in memory; a design that stores it would corrupt a neighbouring location. A transfer to a foreign address must draw no acknowledge and must leave both the pointer and the flag alone. A repeated START between setting the pointer and reading must keep the pointer, and a design that clears it there would return the byte at 0. A final reset must bring back the preset image over written data; a design that keeps written bytes would return the old write.

// File: rtl/smbus_mem_pkg.sv
`timescale 1ns/1ps
package smbus_mem_pkg;

    localparam int MEM_BYTES = 256;
    localparam int PTR_W     = $clog2(MEM_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } bus_state_e;

    typedef struct packed {
        bus_state_e         state;
        logic [3:0]         bitcnt;
        logic [7:0]         shreg;
        logic               rw;
        logic               first;
        logic               oe;
        logic               mack;
        logic               touched;
        logic [PTR_W-1:0]   ptr;
    } fsm_regs_t;

    function automatic logic [7:0] image_byte(input int unsigned idx);
        logic [31:0] t;
        t = idx * 32'd37 + 32'd91;
        return t[7:0];
    endfunction

endpackage

// File: rtl/smbus_sync.sv
`timescale 1ns/1ps
module smbus_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/smbus_cond_detect.sv
`timescale 1ns/1ps
module smbus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise  =  scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s &  prev_q.scl;
    assign start_det =  scl_s &  prev_q.scl &  prev_q.sda & ~sda_s;
    assign stop_det  =  scl_s &  prev_q.scl & ~prev_q.sda &  sda_s;

endmodule

// File: rtl/smbus_mem_array.sv
`timescale 1ns/1ps
module smbus_mem_array
    import smbus_mem_pkg::*;
#(
    parameter int DEPTH = MEM_BYTES,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= image_byte(i);
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/smbus_target_fsm.sv
`timescale 1ns/1ps
module smbus_target_fsm
    import smbus_mem_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rdata,
    output logic             mem_we,
    output logic [7:0]       mem_wdata,
    output logic             rd_load,
    output logic [PTR_W-1:0] ptr_o,
    output logic             sda_oe_o,
    output logic             touched_o,
    output logic             idle_o
);

    fsm_regs_t q, d;
    logic      do_load;

    always_comb begin
        d       = q;
        mem_we  = 1'b0;
        do_load = 1'b0;

        if (start_det) begin
            d.state  = ST_ADDR;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else if (stop_det) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else begin
            unique case (q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        if (q.shreg[7:1] == OWN_ADDR) begin
                            d.oe    = 1'b1;
                            d.rw    = q.shreg[0];
                            d.state = ST_ADDR_ACK;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            do_load = 1'b1;
                        end else begin
                            d.oe     = 1'b0;
                            d.bitcnt = '0;
                            d.first  = 1'b1;
                            d.state  = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.oe      = 1'b1;
                        d.state   = ST_WR_ACK;
                        d.touched = 1'b1;
                        if (q.first) begin
                            d.ptr   = q.shreg;
                            d.first = 1'b0;
                        end else begin
                            mem_we = 1'b1;
                            d.ptr  = q.ptr + 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe     = 1'b0;
                        d.bitcnt = '0;
                        d.state  = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.oe    = 1'b0;
                            d.state = ST_RD_ACK;
                        end else begin
                            d.shreg  = {q.shreg[6:0], 1'b0};
                            d.oe     = ~q.shreg[6];
                            d.bitcnt = q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) do_load = 1'b1;
                        else        d.state = ST_IDLE;
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase

            if (do_load) begin
                d.shreg   = rdata;
                d.oe      = ~rdata[7];
                d.bitcnt  = 4'd1;
                d.ptr     = q.ptr + 1'b1;
                d.touched = 1'b1;
                d.state   = ST_RD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, bitcnt: '0, shreg: '0, rw: 1'b0, first: 1'b0,
                   oe: 1'b0, mack: 1'b0, touched: 1'b0, ptr: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_load   = do_load;
    assign mem_wdata = q.shreg;
    assign ptr_o     = q.ptr;
    assign sda_oe_o  = q.oe;
    assign touched_o = q.touched;
    assign idle_o    = (q.state == ST_IDLE);

endmodule

// File: rtl/smbus_mem_target.sv
`timescale 1ns/1ps
module smbus_mem_target
    import smbus_mem_pkg::*;
#(
    parameter int INST_IDX  = 3,
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    output logic touched_o
);

    localparam logic [6:0] OWN_ADDR = 7'h50 + 7'(INST_IDX);

    logic [1:0]       synced;
    logic             scl_s, sda_s;
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic             mem_we, rd_load, fsm_idle;
    logic [7:0]       mem_wdata, mem_rdata;
    logic [PTR_W-1:0] ptr_q;

    smbus_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (synced)
    );

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    smbus_cond_detect i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smbus_target_fsm #(.OWN_ADDR(OWN_ADDR)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata     (mem_rdata),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .rd_load   (rd_load),
        .ptr_o     (ptr_q),
        .sda_oe_o  (sda_oe_o),
        .touched_o (touched_o),
        .idle_o    (fsm_idle)
    );

    smbus_mem_array #(.DEPTH(MEM_BYTES)) i_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (ptr_q),
        .wdata (mem_wdata),
        .raddr (ptr_q),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/smbus_mem_target_chk.sv
`timescale 1ns/1ps
module smbus_mem_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       touched,
    input logic       mem_we,
    input logic       rd_load,
    input logic       stop_seen,
    input logic       idle,
    input logic [7:0] ptr
);

    assert_wr_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ptr == 8'($past(ptr) + 8'd1));

    assert_rd_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> ptr == 8'($past(ptr) + 8'd1));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        touched |=> touched);

    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !sda_oe);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sda_oe);

    assert_no_dual_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && rd_load));

endmodule

bind smbus_mem_target smbus_mem_target_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe_o),
    .touched   (touched_o),
    .mem_we    (mem_we),
    .rd_load   (rd_load),
    .stop_seen (stop_det),
    .idle      (fsm_idle),
    .ptr       (ptr_q)
);

// File: tb/test_smbus_mem_target.sv
`timescale 1ns/1ps
module test_smbus_mem_target;

    localparam int H = 8;
    localparam logic [6:0] DEV = 7'h53;
    localparam logic [6:0] FOREIGN = 7'h58;
    // vector: {is_read, ptr, value}: write stores value at ptr; read expects value at ptr
    localparam logic [16:0] VEC [6] = '{
        {1'b1, 8'h10, 8'hAB},
        {1'b0, 8'h20, 8'hC3},
        {1'b1, 8'h20, 8'hC3},
        {1'b0, 8'hFF, 8'h11},
        {1'b1, 8'hFF, 8'h11},
        {1'b1, 8'h21, 8'h20}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, touched;
    logic sda_line;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #2.5 clk = ~clk;

    smbus_mem_target i_smbus_mem_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .touched_o (touched)
    );

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold(H);
        m_scl = 1'b1; hold(H);
        m_sda = 1'b0; hold(H);
        m_scl = 1'b0; hold(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(H);
        m_scl = 1'b1; hold(H);
        m_sda = 1'b1; hold(H);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    hold(H);
        m_scl = 1'b1; hold(H);
        m_scl = 1'b0; hold(H);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; hold(H);
        m_scl = 1'b1; hold(H/2);
        b = sda_line; hold(H/2);
        m_scl = 1'b0; hold(H);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(p, a);
        bus_stop();
    endtask

    task automatic write_one(input logic [7:0] p, input logic [7:0] v, input string req);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(p, a);
        send_byte(v, a);
        check(req, {7'd0, a}, 8'd1);
        bus_stop();
    endtask

    task automatic read_one(output logic [7:0] v);
        logic a;
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin
        logic       a;
        logic [7:0] v;

        hold(5);
        rst_n = 1'b1;
        hold(5);
        // R5: reset state
        check("R5 sda released after reset", {7'd0, sda_oe}, 8'd0);
        check("R5 flag clear after reset", {7'd0, touched}, 8'd0);

        // R1: foreign address draws no ACK and changes nothing
        bus_start();
        send_byte({FOREIGN, 1'b0}, a);
        check("R1 foreign address not acknowledged", {7'd0, a}, 8'd0);
        send_byte(8'h30, a);
        send_byte(8'h77, a);
        bus_stop();
        check("R1 foreign transfer leaves flag", {7'd0, touched}, 8'd0);

        // R1, R5: own address ACK, pointer 0 after reset
        bus_start();
        send_byte({DEV, 1'b1}, a);
        check("R1 own address acknowledged", {7'd0, a}, 8'd1);
        recv_byte(1'b0, v);
        bus_stop();
        check("R5 first read at pointer 0", v, 8'h5B);
        check("R6 flag set after read", {7'd0, touched}, 8'd1);
        read_one(v);
        check("R4 read advances pointer", v, 8'h80);

        // table walk
        for (int k = 0; k < 6; k++) begin
            if (VEC[k][16]) begin
                set_ptr(VEC[k][15:8]);
                read_one(v);
                check("R4 table read", v, VEC[k][7:0]);
            end else begin
                write_one(VEC[k][15:8], VEC[k][7:0], "R3 table write ack");
            end
        end

        // R2, R3: wrapping multi-byte write
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'hFE, a);
        check("R2 pointer byte acknowledged", {7'd0, a}, 8'd1);
        send_byte(8'hA1, a);
        send_byte(8'hA2, a);
        send_byte(8'hA3, a);
        check("R2 data byte acknowledged", {7'd0, a}, 8'd1);
        bus_stop();

        // R4: sequential read across the wrap, NACK ends
        set_ptr(8'hFE);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b1, v);
        check("R3 byte at FE", v, 8'hA1);
        recv_byte(1'b1, v);
        check("R3 byte at FF", v, 8'hA2);
        recv_byte(1'b0, v);
        check("R3 wrapped byte at 00", v, 8'hA3);
        hold(H);
        check("R4 SDA released after NACK", {7'd0, sda_oe}, 8'd0);
        bus_stop();
        check("R8 SDA released after STOP", {7'd0, sda_oe}, 8'd0);
        read_one(v);
        check("R4 pointer continues after wrap", v, 8'h80);

        // R2: pointer byte not stored
        set_ptr(8'h30);
        read_one(v);
        check("R2 pointer-only write then read", v, 8'h4B);
        set_ptr(8'h02);
        read_one(v);
        check("R2 old pointer location untouched", v, 8'hA5);

        // R7: repeated START keeps pointer
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h40, a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        check("R7 address ACK after repeated START", {7'd0, a}, 8'd1);
        recv_byte(1'b0, v);
        bus_stop();
        check("R7 read after repeated START", v, 8'h9B);

        // R5: reset restores the image
        rst_n = 1'b0;
        hold(3);
        rst_n = 1'b1;
        hold(5);
        check("R6 flag cleared by reset", {7'd0, touched}, 8'd0);
        read_one(v);
        check("R5 pointer 0 after second reset", v, 8'h5B);
        set_ptr(8'h20);
        read_one(v);
        check("R5 written byte replaced by image", v, 8'hFB);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule